// File: doc/BRIEF.md
# ATAN2 Special-Operand Resolver

This combinational block sits in front of a two-argument arctangent datapath. It receives the ordinate `y` and the abscissa `x` as IEEE754 single-precision words. It decides whether a NaN, an infinity or a signed zero already fixes the result of atan2(y, x).

When such an operand fixes the result, the block drives the final 32-bit answer and raises `special`. That answer is either a quietened NaN or a signed multiple of π taken from a small constant set. The arctangent core then does no work for that operation. When `special` is low, the operands are two finite nonzero numbers, and the core must compute the result. In that case the `result` output carries no meaning.

The rules are tried in a fixed order: NaNs first, then infinities, then zeros, and the first rule that matches wins. All constants are FP32 values rounded to nearest. Their sign is copied from bit 31 of `y`.

Top module: `atan2_special_resolver`

## Requirements
- R1: If `x` is a NaN (exponent field all ones, mantissa nonzero), `special` is 1 and `result` is `x` with mantissa bit 22 forced to 1, whatever `y` holds.
- R2: If `x` is not a NaN and `y` is a NaN, `special` is 1 and `result` is `y` with mantissa bit 22 forced to 1.
- R3: `invalid` is 1 exactly when at least one operand is a signalling NaN (a NaN with mantissa bit 22 clear); otherwise it is 0.
- R4: If `x` is +∞ and `y` is not a NaN, the result is π/4 (0x3F490FDB) when `y` is infinite and zero (0x00000000) otherwise, with bit 31 taken from `y`.
- R5: If `x` is −∞ and `y` is not a NaN, the result is 3π/4 (0x4016CBE4) when `y` is infinite and π (0x40490FDB) otherwise, with bit 31 taken from `y`.
- R6: If `x` is finite and `y` is ±∞, the result is π/2 (0x3FC90FDB) with bit 31 taken from `y`.
- R7: If `x` is +0 or −0 and `y` is finite and nonzero (subnormals included), the result is π/2 with bit 31 taken from `y`.
- R8: If `y` is ±0 and `x` is finite (zero included), the result is a zero when bit 31 of `x` is 0 and π when it is 1, with bit 31 taken from `y`.
- R9: `special` is 0 exactly when both operands are finite and nonzero; a subnormal counts as finite and nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| y_in | input | 32 | Ordinate operand, FP32 encoding |
| x_in | input | 32 | Abscissa operand, FP32 encoding |
| result | output | 32 | Resolved FP32 result; meaningful only while `special` is 1 |
| special | output | 1 | 1 when the operands fix the result, 0 when the arctangent core must compute it |
| invalid | output | 1 | Invalid-operation flag, raised for a signalling NaN operand |

## Verification
The assertions assume that both operands are two-state and stable while they are sampled. They rely on no particular mix of operand values, because every 32-bit pair has one defined outcome. The bench drives each operand only from a fixed table and a generator whose exponent field takes the values zero, all ones, or a value in between. Every pattern is therefore a legal FP32 word, and each operand class appears in both signs. The bench applies each new pair one clock phase before it samples the outputs.

// File: rtl/atan2_sp_pkg.sv
// Package: shared FP32 field geometry, operand class record and result constants
// for the atan2 special-operand resolver. Assumes IEEE754 binary32 layout.
package atan2_sp_pkg;
    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int WORD_W  = 1 + EXP_W + MAN_W;
    localparam int SIGN_B  = WORD_W - 1;
    localparam int QUIET_B = MAN_W - 1;

    // Magnitudes (sign bit clear), rounded to nearest.
    localparam logic [WORD_W-1:0] MAG_ZERO  = '0;
    localparam logic [WORD_W-1:0] MAG_PI_4  = 32'h3F49_0FDB;
    localparam logic [WORD_W-1:0] MAG_PI_2  = 32'h3FC9_0FDB;
    localparam logic [WORD_W-1:0] MAG_3PI_4 = 32'h4016_CBE4;
    localparam logic [WORD_W-1:0] MAG_PI    = 32'h4049_0FDB;

    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_snan;
        logic is_inf;
        logic is_zero;
    } fp_class_t;

    // Attach a sign bit to a magnitude constant.
    function automatic logic [WORD_W-1:0] with_sign(input logic s,
                                                    input logic [WORD_W-1:0] mag);
        return {s, mag[SIGN_B-1:0]};
    endfunction
endpackage

// File: rtl/atan2_fp_classify.sv
// Module: classifies one FP32 word into sign, NaN, signalling NaN, infinity
// and zero flags. Assumes a two-state input; subnormals are neither zero nor special.
module atan2_fp_classify
    import atan2_sp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fp_class_t         cls
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_ones;
    logic             man_zero;

    // Split fields and derive the class flags.
    always_comb begin
        exp_f       = word[SIGN_B-1:MAN_W];
        man_f       = word[MAN_W-1:0];
        exp_ones    = &exp_f;
        man_zero    = (man_f == '0);
        cls.sign    = word[SIGN_B];
        cls.is_nan  = exp_ones && !man_zero;
        cls.is_snan = exp_ones && !man_zero && !man_f[QUIET_B];
        cls.is_inf  = exp_ones && man_zero;
        cls.is_zero = (word[SIGN_B-1:0] == '0);
    end
endmodule

// File: rtl/atan2_nan_select.sv
// Module: NaN stage. Returns x quietened when x is a NaN, else y quietened when
// y is a NaN; raises the invalid flag for any signalling NaN operand.
module atan2_nan_select
    import atan2_sp_pkg::*;
(
    input  logic [WORD_W-1:0] y_word,
    input  logic [WORD_W-1:0] x_word,
    input  fp_class_t         y_cls,
    input  fp_class_t         x_cls,
    output logic              hit,
    output logic [WORD_W-1:0] value,
    output logic              inv
);
    localparam logic [WORD_W-1:0] QUIET_MASK = WORD_W'(1) << QUIET_B;

    // x has priority over y; the quiet bit is forced on the chosen payload.
    always_comb begin
        hit   = x_cls.is_nan || y_cls.is_nan;
        value = (x_cls.is_nan ? x_word : y_word) | QUIET_MASK;
        inv   = x_cls.is_snan || y_cls.is_snan;
    end
endmodule

// File: rtl/atan2_rule_resolve.sv
// Module: infinity and zero rules for NaN-free operands, in priority order:
// x infinite, then y infinite, then x zero with y nonzero, then y zero.
// Assumes the NaN stage overrides this output whenever a NaN is present.
module atan2_rule_resolve
    import atan2_sp_pkg::*;
(
    input  fp_class_t         y_cls,
    input  fp_class_t         x_cls,
    output logic              hit,
    output logic [WORD_W-1:0] value
);
    // First matching rule picks the magnitude; sign always follows y.
    always_comb begin
        logic [WORD_W-1:0] mag;
        hit = 1'b1;
        mag = MAG_ZERO;
        if (x_cls.is_nan || y_cls.is_nan) begin
            hit = 1'b0;
        end else if (x_cls.is_inf) begin
            if (!x_cls.sign) mag = y_cls.is_inf ? MAG_PI_4  : MAG_ZERO;
            else             mag = y_cls.is_inf ? MAG_3PI_4 : MAG_PI;
        end else if (y_cls.is_inf) begin
            mag = MAG_PI_2;
        end else if (x_cls.is_zero && !y_cls.is_zero) begin
            mag = MAG_PI_2;
        end else if (y_cls.is_zero) begin
            mag = x_cls.sign ? MAG_PI : MAG_ZERO;
        end else begin
            hit = 1'b0;
        end
        value = with_sign(y_cls.sign, mag);
    end
endmodule

// File: rtl/atan2_special_resolver.sv
// Module: top of the atan2 special-operand resolver. Classifies both operands,
// runs the NaN stage ahead of the infinity/zero rules and merges the outcome.
// Purely combinational; assumes two-state inputs.
module atan2_special_resolver
    import atan2_sp_pkg::*;
(
    input  logic [31:0] y_in,
    input  logic [31:0] x_in,
    output logic [31:0] result,
    output logic        special,
    output logic        invalid
);
    localparam int N_OPS = 2;

    logic [WORD_W-1:0] op_word [N_OPS];
    fp_class_t         op_cls  [N_OPS];
    logic              nan_hit;
    logic              rule_hit;
    logic [WORD_W-1:0] nan_val;
    logic [WORD_W-1:0] rule_val;

    // Operand 0 is y, operand 1 is x.
    always_comb begin
        op_word[0] = y_in;
        op_word[1] = x_in;
    end

    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
        atan2_fp_classify i_cls (.word(op_word[i]), .cls(op_cls[i]));
    end

    atan2_nan_select i_nan (
        .y_word(op_word[0]), .x_word(op_word[1]),
        .y_cls(op_cls[0]),   .x_cls(op_cls[1]),
        .hit(nan_hit), .value(nan_val), .inv(invalid)
    );

    atan2_rule_resolve i_rule (
        .y_cls(op_cls[0]), .x_cls(op_cls[1]),
        .hit(rule_hit), .value(rule_val)
    );

    // NaN outcome outranks every infinity/zero rule.
    always_comb begin
        special = nan_hit || rule_hit;
        result  = nan_hit ? nan_val : rule_val;
    end
endmodule

// File: rtl/atan2_special_checker.sv
// Module: port-level checker for the resolver, bound to every instance.
// Uses immediate assertions because the block has no clock.
module atan2_special_checker (
    input logic [31:0] y_in,
    input logic [31:0] x_in,
    input logic [31:0] result,
    input logic        special,
    input logic        invalid
);
    logic x_nan, y_nan, x_fin, y_fin, x_nz, y_nz;

    // Independent operand view taken from the raw ports.
    always_comb begin
        x_nan = (x_in[30:23] == 8'hFF) && (x_in[22:0] != 0);
        y_nan = (y_in[30:23] == 8'hFF) && (y_in[22:0] != 0);
        x_fin = (x_in[30:23] != 8'hFF);
        y_fin = (y_in[30:23] != 8'hFF);
        x_nz  = (x_in[30:0] != 0);
        y_nz  = (y_in[30:0] != 0);
    end

    // Property checks on each settled input pair.
    always_comb begin
        p_x_nan_wins_r1: assert (!x_nan || (special && result == (x_in | 32'h0040_0000)));
        p_y_nan_r2: assert (x_nan || !y_nan || (special && result == (y_in | 32'h0040_0000)));
        p_invalid_needs_nan_r3: assert (!invalid || ((x_nan || y_nan) && special));
        p_sign_follows_y_r6: assert (!special || x_nan || y_nan || result[31] == y_in[31]);
        p_core_only_finite_r9: assert (special != (x_fin && y_fin && x_nz && y_nz));
    end
endmodule

bind atan2_special_resolver atan2_special_checker i_chk (
    .y_in(y_in), .x_in(x_in), .result(result), .special(special), .invalid(invalid)
);

// File: tb/test_atan2_special_resolver.sv
// Bench: table sweep of every operand-class pair in both signs, then a
// generated sweep, with expected values derived from the requirements.
module test_atan2_special_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] y_in = '0;
    logic [31:0] x_in = '0;
    logic [31:0] result;
    logic        special;
    logic        invalid;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    atan2_special_resolver i_atan2_special_resolver (
        .y_in(y_in), .x_in(x_in), .result(result), .special(special), .invalid(invalid)
    );

    localparam logic [31:0] QB = 32'h0040_0000;

    function automatic bit is_nan(input logic [31:0] w);
        return w[30:23] == 8'hFF && w[22:0] != 0;
    endfunction
    function automatic bit is_snan(input logic [31:0] w);
        return is_nan(w) && !w[22];
    endfunction
    function automatic bit is_inf(input logic [31:0] w);
        return w[30:23] == 8'hFF && w[22:0] == 0;
    endfunction
    function automatic bit is_zero(input logic [31:0] w);
        return w[30:0] == 0;
    endfunction

    // Expected outcome built from R1..R9; tag names the rule that applies.
    task automatic expect_of(input logic [31:0] y, input logic [31:0] x,
                             output bit sp, output logic [31:0] r,
                             output bit inv, output string tag);
        inv = is_snan(x) || is_snan(y);
        sp  = 1'b1;
        if (is_nan(x)) begin r = x | QB; tag = "R1"; end
        else if (is_nan(y)) begin r = y | QB; tag = "R2"; end
        else if (is_inf(x) && !x[31]) begin
            r = {y[31], is_inf(y) ? 31'h3F490FDB : 31'h0}; tag = "R4";
        end else if (is_inf(x)) begin
            r = {y[31], is_inf(y) ? 31'h4016CBE4 : 31'h40490FDB}; tag = "R5";
        end else if (is_inf(y)) begin r = {y[31], 31'h3FC90FDB}; tag = "R6"; end
        else if (is_zero(x) && !is_zero(y)) begin r = {y[31], 31'h3FC90FDB}; tag = "R7"; end
        else if (is_zero(y)) begin r = {y[31], x[31] ? 31'h40490FDB : 31'h0}; tag = "R8"; end
        else begin sp = 1'b0; r = 'x; tag = "R9"; end
    endtask

    // Drive one pair after a rising edge, sample at the falling edge.
    task automatic apply_pair(input logic [31:0] y, input logic [31:0] x);
        bit sp, inv;
        logic [31:0] r;
        string tag;
        @(posedge clk);
        y_in = y;
        x_in = x;
        @(negedge clk);
        expect_of(y, x, sp, r, inv, tag);
        checks++;
        if (special !== sp) begin
            errors++;
            $display("FAIL %s special y=%h x=%h actual=%b expected=%b", tag, y, x, special, sp);
        end
        if (sp) begin
            checks++;
            if (result !== r) begin
                errors++;
                $display("FAIL %s result y=%h x=%h actual=%h expected=%h", tag, y, x, result, r);
            end
        end
        checks++;
        if (invalid !== inv) begin
            errors++;
            $display("FAIL R3 invalid y=%h x=%h actual=%b expected=%b", y, x, invalid, inv);
        end
    endtask

    logic [31:0] tbl [14] = '{
        32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h807F_FFFF,
        32'h3F80_0000, 32'hC2F6_0000, 32'h7F7F_FFFF, 32'h0080_0000,
        32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0001, 32'hFFFF_FFFF,
        32'h7F80_0001, 32'hFFA0_0000
    };

    initial begin
        logic [31:0] lfsr;
        logic [31:0] ya, xa;
        // Reset-time state: zero operands give +0 via the y-zero rule (R8).
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (special !== 1'b1 || result !== 32'h0 || invalid !== 1'b0) begin
            errors++;
            $display("FAIL R8 reset state actual=%b/%h/%b expected=1/00000000/0",
                     special, result, invalid);
        end
        // Table sweep covering R1 to R9 in every sign combination.
        for (int i = 0; i < 14; i++)
            for (int j = 0; j < 14; j++)
                apply_pair(tbl[i], tbl[j]);
        // Generated sweep: exponent forced to 0, all ones, or mantissa-driven.
        lfsr = 32'hACE1_2468;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ya = lfsr;
            if (lfsr[3:2] == 2'd0) ya[30:23] = 8'h00;
            if (lfsr[3:2] == 2'd1) ya[30:23] = 8'hFF;
            if (lfsr[5:4] == 2'd0) ya[22:0]  = '0;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            xa = {lfsr[15:0], lfsr[31:16]};
            if (lfsr[7:6] == 2'd0) xa[30:23] = 8'h00;
            if (lfsr[7:6] == 2'd1) xa[30:23] = 8'hFF;
            if (lfsr[9:8] == 2'd0) xa[22:0]  = '0;
            apply_pair(ya, xa);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule